// File: doc/BRIEF.md
# Cross-Lane Data Swizzle Unit

This block moves 32-bit values between the lanes of a 64-lane vector. A 16-bit pattern word picks the lane mapping. The second offset byte forms bits 15:8 of the pattern and the first offset byte forms bits 7:0. Every destination lane works out its source lane in parallel, using one of two mappings.

- **Quad mode** swaps data within aligned groups of four lanes.
- **Mask mode** builds the source from AND, OR and XOR masks on the low five lane-number bits. In this mode data never leaves its own 32-lane half.

An execution mask marks which lanes take part. Lanes that are switched off are never written. An active lane that picks a switched-off source receives zero.

A start strobe captures the vector, the mask and the pattern. A small controller then counts a fixed latency of 24 cycles and raises done for one cycle, together with the per-lane write enables. The controller has three states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for work |
| `ST_RUN` | Latency count in progress |
| `ST_DONE` | Result valid for one cycle |

Its transitions are:

- `IDLE->RUN` on an accepted start.
- `RUN->DONE` when the count reaches the latency.
- `DONE->IDLE` unconditionally.

Busy is high in `ST_RUN` and `ST_DONE`. A start seen while busy is dropped.

Top module: `swz_unit`

## Requirements
- R1: The pattern is {offset_hi, offset_lo}. Pattern bit 15 = 1 selects quad mode and bit 15 = 0 selects mask mode. In quad mode, pattern bits 14:8 have no effect.
- R2: Quad mode: destination lane L takes lane (L with bits 1:0 cleared) + pattern[2k+1:2k], where k = L mod 4.
- R3: Mask mode: with and = pattern[4:0], or = pattern[9:5] and xor = pattern[14:10], the low five source bits are ((L[4:0] & and) | or) ^ xor.
- R4: Mask mode: bit 5 of the source lane equals bit 5 of the destination lane, so lanes 32-63 read only from lanes 32-63.
- R5: A destination lane whose mask bit is 0 has lane_we = 0 and a result of zero.
- R6: An active destination lane whose selected source lane has mask bit 0 gets the value zero.
- R7: An all-zero execution mask still completes with done after the full latency, and lane_we is all zero.
- R8: done rises exactly 24 rising clock edges after the edge that accepts start, and stays high for exactly one cycle.
- R9: busy is high from the accepting edge until done falls. A start asserted while busy does not change the running operation's timing or result.
- R10: lane_we equals the captured mask only while done is high, and is zero otherwise. The result does not change from the done cycle until the next accepted start.
- R11: After reset, busy, done and lane_we are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only in idle) |
| exec_mask | input | 64 | Per-lane activity mask |
| offset_lo | input | 8 | Pattern bits 7:0 |
| offset_hi | input | 8 | Pattern bits 15:8 |
| data_in | input | 2048 | Source vector, lane L at bits 32L+31:32L |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2048 | Swizzled vector, same lane layout |
| lane_we | output | 64 | Per-lane write enable, valid with done |

## Verification
A controller stuck in or skipping `ST_RUN` shows at the ports straight away: done arrives early or late compared with the 24-edge count, or busy drops inside the window. A corrupted index path shows as a wrong lane value in the single done cycle. A wrongly accepted restart shows as a result built from the later inputs, or as done shifted by the restart offset. Each operation's bench check therefore looks at done timing, busy on every cycle of the window, and the full result vector against a lane model.

// File: rtl/swz_pkg.sv
package swz_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } swz_state_e;

    localparam int PAT_W    = 16;
    localparam int MODE_BIT = 15;
    localparam int FIELD_W  = 5;
    localparam int QUAD_SZ  = 4;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
    import swz_pkg::*;
#(
    parameter int LATENCY = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LATENCY + 1);

    swz_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = CW'(1);
                end
            end
            ST_RUN: begin
                if (cnt_q == CW'(LATENCY)) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        accept = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start;
            ST_RUN:  busy = 1'b1;
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: the completion state lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> state_q == ST_IDLE);
    // R9: a run is never abandoned back to idle
    p_run_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q != ST_IDLE);
endmodule

// File: rtl/swz_quad_map.sv
module swz_quad_map
    import swz_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic [2*QUAD_SZ-1:0]  sel_bits,
    output logic [LANES*IDXW-1:0] src_idx
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int K = g % QUAD_SZ;
        localparam logic [IDXW-1:0] BASE = IDXW'(g - K);
        assign src_idx[g*IDXW +: IDXW] = BASE | IDXW'(sel_bits[2*K +: 2]);
    end
endmodule

// File: rtl/swz_mask_map.sv
module swz_mask_map
    import swz_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic [FIELD_W-1:0]    and_m,
    input  logic [FIELD_W-1:0]    or_m,
    input  logic [FIELD_W-1:0]    xor_m,
    output logic [LANES*IDXW-1:0] src_idx
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [IDXW-1:0] LANE_ID = IDXW'(g);
        logic [FIELD_W-1:0] low;
        assign low = ((LANE_ID[FIELD_W-1:0] & and_m) | or_m) ^ xor_m;
        if (IDXW > FIELD_W) begin : g_half
            assign src_idx[g*IDXW +: IDXW] = {LANE_ID[IDXW-1:FIELD_W], low};
        end else begin : g_flat
            assign src_idx[g*IDXW +: IDXW] = IDXW'(low);
        end
    end
endmodule

// File: rtl/swz_gather.sv
module swz_gather #(
    parameter int LANES = 64,
    parameter int DW    = 32,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0]   data,
    input  logic [LANES-1:0]      mask,
    input  logic [LANES*IDXW-1:0] src_idx,
    output logic [LANES*DW-1:0]   res
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDXW-1:0] s;
        assign s = src_idx[g*IDXW +: IDXW];
        assign res[g*DW +: DW] = (mask[g] && mask[s]) ? data[s*DW +: DW] : '0;
    end
endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int DW      = 32,
    parameter int LATENCY = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LANES-1:0]    exec_mask,
    input  logic [7:0]          offset_lo,
    input  logic [7:0]          offset_hi,
    input  logic [LANES*DW-1:0] data_in,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] result,
    output logic [LANES-1:0]    lane_we
);
    localparam int IDXW = $clog2(LANES);
    localparam int AGEW = $clog2(LATENCY + 2);

    logic                accept;
    logic [LANES*DW-1:0] data_q;
    logic [LANES-1:0]    mask_q;
    logic [PAT_W-1:0]    pat_q;
    logic [LANES*IDXW-1:0] quad_idx, msk_idx, sel_idx;

    swz_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
            pat_q  <= '0;
        end else if (accept) begin
            data_q <= data_in;
            mask_q <= exec_mask;
            pat_q  <= {offset_hi, offset_lo};
        end
    end

    swz_quad_map #(.LANES(LANES), .IDXW(IDXW)) u_quad (
        .sel_bits (pat_q[2*QUAD_SZ-1:0]),
        .src_idx  (quad_idx)
    );

    swz_mask_map #(.LANES(LANES), .IDXW(IDXW)) u_mask (
        .and_m   (pat_q[FIELD_W-1:0]),
        .or_m    (pat_q[2*FIELD_W-1:FIELD_W]),
        .xor_m   (pat_q[3*FIELD_W-1:2*FIELD_W]),
        .src_idx (msk_idx)
    );

    assign sel_idx = pat_q[MODE_BIT] ? quad_idx : msk_idx;

    swz_gather #(.LANES(LANES), .DW(DW), .IDXW(IDXW)) u_gather (
        .data    (data_q),
        .mask    (mask_q),
        .src_idx (sel_idx),
        .res     (result)
    );

    assign lane_we = done ? mask_q : '0;

    // Age since the accepting edge, used only by the latency check
    logic [AGEW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (accept) age_q <= '0;
        else if (busy && age_q != '1) age_q <= age_q + AGEW'(1);
    end

    // R8: done appears exactly LATENCY edges after acceptance
    p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> age_q == AGEW'(LATENCY));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: captured operands cannot change while busy
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mask_q) && $stable(pat_q) && $stable(data_q));
    // R10: no write enable outside the done cycle
    p_we_only_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> lane_we == '0);
    // R10: result frozen across the done cycle
    p_res_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(result));

    // R6: inactive source yields zero on each active lane
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic [IDXW-1:0] s_g;
        assign s_g = sel_idx[g*IDXW +: IDXW];
        p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done && mask_q[g] && !mask_q[s_g] |-> result[g*DW +: DW] == '0);
    end
endmodule

// File: tb/swz_unit_tb_top.sv
module swz_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 64;
    localparam int DW = 32;
    localparam int LAT = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANES-1:0] exec_mask = '0;
    logic [7:0] offset_lo = '0, offset_hi = '0;
    logic [LANES*DW-1:0] data_in = '0;
    logic busy, done;
    logic [LANES*DW-1:0] result;
    logic [LANES-1:0] lane_we;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swz_unit #(.LANES(LANES), .DW(DW), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .exec_mask(exec_mask),
        .offset_lo(offset_lo), .offset_hi(offset_hi), .data_in(data_in),
        .busy(busy), .done(done), .result(result), .lane_we(lane_we)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input logic [LANES*DW-1:0] act,
                           input logic [LANES*DW-1:0] exp, input string req);
        int bad = -1;
        n_checks++;
        for (int l = LANES - 1; l >= 0; l--)
            if (act[l*DW +: DW] !== exp[l*DW +: DW]) bad = l;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s result lane %0d: actual %h expected %h", req, bad,
                     act[bad*DW +: DW], exp[bad*DW +: DW]);
        end
    endtask

    function automatic logic [LANES*DW-1:0] mk_data(input int seed);
        logic [LANES*DW-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[l*DW +: DW] = {8'hC3, 8'(seed), 8'(l), 8'(l * 7 + seed)};
        return v;
    endfunction

    function automatic logic [LANES*DW-1:0] model(input logic [LANES-1:0] m,
            input logic [15:0] pat, input logic [LANES*DW-1:0] d);
        logic [LANES*DW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            int src;
            if (pat[15]) begin
                src = (l / 4) * 4 + int'(pat[2 * (l % 4) +: 2]);
            end else begin
                int a = int'(pat[4:0]);
                int o = int'(pat[9:5]);
                int x = int'(pat[14:10]);
                src = (((l % 32) & a) | o) ^ x;
                if (l >= 32) src = src + 32;
            end
            r[l*DW +: DW] = (m[l] && m[src]) ? d[src*DW +: DW] : '0;
        end
        return r;
    endfunction

    // One operation, optional restart attempt in mid-flight
    task automatic run_op(input logic [LANES-1:0] m, input logic [7:0] lo,
                          input logic [7:0] hi, input int seed,
                          input bit poke, input string req);
        logic [LANES*DW-1:0] d = mk_data(seed);
        logic [LANES*DW-1:0] exp = model(m, {hi, lo}, d);
        logic [LANES*DW-1:0] held;
        bit early = 0;
        bit drop = 0;
        @(negedge clk);
        exec_mask = m; offset_lo = lo; offset_hi = hi; data_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            if (poke && k == 10) begin
                exec_mask = ~m; offset_lo = ~lo; offset_hi = ~hi;
                data_in = mk_data(seed + 99); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done) early = 1;
            if (!busy) drop = 1;
        end
        start = 1'b0;
        chk(!early, "R8", {req, " done early"}, 64'(early), 64'd0);
        chk(!drop, "R9", {req, " busy dropped"}, 64'(drop), 64'd0);
        @(negedge clk);
        chk(done === 1'b1, "R8", {req, " done at latency"}, 64'(done), 64'd1);
        chk_vec(result, exp, req);
        chk(lane_we === m, req, "lane_we", lane_we, m);
        held = result;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8", {req, " done/busy after"},
            {62'd0, busy, done}, 64'd0);
        chk(lane_we === '0, "R10", {req, " we after done"}, lane_we, 64'd0);
        chk_vec(result, held, "R10 hold");
    endtask

    task automatic t_reset();
        chk(busy === 1'b0 && done === 1'b0, "R11", "busy/done",
            {62'd0, busy, done}, 64'd0);
        chk(lane_we === '0, "R11", "lane_we", lane_we, 64'd0);
    endtask

    // R1 R2: reversal within each quad; hi byte bits 14:8 unused in quad
    task automatic t_quad();
        run_op('1, 8'b00_01_10_11, 8'h80, 3, 0, "R2 reverse");
        run_op('1, 8'h00, 8'hFF, 5, 0, "R1 R2 broadcast");
        run_op('1, 8'b10_11_00_01, 8'hA5, 7, 0, "R2 pair swap");
    endtask

    // R3 R4: xor=1 swaps neighbours; or=5 broadcasts lane 5 of each half
    task automatic t_mask();
        run_op('1, 8'h1F, 8'h04, 9, 0, "R3 xor swap");
        run_op('1, 8'hA0, 8'h00, 11, 0, "R4 or broadcast");
        run_op('1, 8'h0F, 8'h7C, 13, 0, "R3 R4 mixed");
    endtask

    // R5 R6: alternate lanes inactive
    task automatic t_inactive();
        run_op({32{2'b01}}, 8'b00_01_10_11, 8'h80, 15, 0, "R5 R6 quad");
        run_op(64'hF0F0_0F0F_3C3C_C3C3, 8'h1F, 8'h0C, 17, 0, "R5 R6 mask");
    endtask

    task automatic t_zero_mask();
        run_op('0, 8'h1B, 8'h80, 19, 0, "R7 empty");
    endtask

    task automatic t_busy_ignore();
        run_op('1, 8'b01_00_11_10, 8'h80, 21, 1, "R9 restart ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quad();
        t_mask();
        t_inactive();
        t_zero_mask();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end
endmodule